// File: doc/BRIEF.md
# Three-Source Maskable Interrupt Front End with Cascade and Slave Type Capture

This block sits between three asynchronous interrupt lines and a CPU core. Each line first passes through a two-stage synchronizer. A per-source configuration bit then treats the line either as a level request or as a rising-edge event that sets a sticky pending bit. A per-source mask bit screens the result. Of the requests that remain, the lowest-numbered one is presented to the CPU as a request flag plus a two-bit source index. The CPU answers with a one-cycle acknowledge.

Two alternative pin roles are supported. In cascade mode, line 2 stops being an interrupt input and becomes a driven acknowledge output. When the CPU accepts source 0, that output pulses. The external controller then drives an 8-bit type on a data bus, and the block captures that type on the last cycle of the pulse. In slave mode, line 1 stops being an interrupt input and becomes a select strobe. A rise on source 0 arms the block. A later rise on the strobe then captures the type that an outside master has placed on the bus. If both mode bits are set, cascade mode takes precedence.

Top module: `mirq_front`

## Requirements
- R1: In level mode an unmasked line raises `cpu_req_o` on the second rising clock edge after the pin goes high, and not before.
- R2: In edge mode the pending bit is set on the third edge after a pin rise. It stays set after the pin falls. It clears on the edge that samples `cpu_ack_i` while `cpu_src_o` names that source.
- R3: A source whose `cfg_mask_i` bit is 1 never appears on `cpu_req_o`/`cpu_src_o`. An edge event recorded while masked is kept and appears as soon as the mask bit returns to 0.
- R4: A level-mode request follows the live synchronized line. If the line drops before acknowledge, the request disappears two edges later.
- R5: Priority is fixed. Among active sources, the one with the lowest index wins. `cpu_src_o` encodes source n as the value n (0, 1 or 2).
- R6: In cascade mode `inta_oe_o` is 1 and line 2 never produces a request. Acknowledging source 0 drives `inta_o` high for ACK_CYC cycles (default 2), starting at the edge that samples the acknowledge.
- R7: In cascade mode `type_o` takes the bus value present at the last edge of the acknowledge pulse. `type_valid_o` is high for exactly the one cycle after `inta_o` falls.
- R8: In slave mode line 1 never produces a request. After source 0's synchronized line has risen, a synchronized rise on line 1 captures the bus, and `type_valid_o` is high for one cycle, three edges after the select pin rises.
- R9: In slave mode a select rise with no earlier rise on source 0 leaves `type_valid_o` low.
- R10: After reset `cpu_req_o`, `inta_o` and `type_valid_o` are 0, and `type_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | 3 | Asynchronous request lines; bit 1 is the select strobe in slave mode, bit 2 is unused in cascade mode |
| cfg_edge_i | input | 3 | Per-source trigger: 1 = rising edge, 0 = level |
| cfg_mask_i | input | 3 | Per-source mask: 1 = blocked |
| cfg_cascade_i | input | 1 | Cascade mode for source 0 |
| cfg_slave_i | input | 1 | Slave mode (ignored while cascade is set) |
| type_bus_i | input | 8 | External interrupt type bus |
| cpu_ack_i | input | 1 | CPU accepts the presented source |
| cpu_req_o | output | 1 | A request is presented |
| cpu_src_o | output | 2 | Index of the presented source |
| inta_o | output | 1 | Cascade acknowledge pulse, driven on line 2 |
| inta_oe_o | output | 1 | Output enable for line 2 |
| type_o | output | 8 | Captured interrupt type |
| type_valid_o | output | 1 | One-cycle strobe for a new type |

## Verification
The hardest state to reach from the ports is the armed-but-not-yet-selected condition of slave mode. It shows up nowhere except through the later capture. The stimulus first raises the select line with no source 0 rise and watches `type_valid_o` stay low for several cycles. It then raises source 0, waits for the pending request, and only after that raises the select, so that both the rejected path and the accepted path are exercised. The cascade capture timing is checked by changing the bus between the first and last cycles of the acknowledge pulse, which shows that the value is sampled on the last cycle.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int SRC_N = 3;
  typedef logic [1:0] src_idx_t;

  // Lowest-index active source wins; returns {hit, index}.
  function automatic logic [2:0] pick_first(input logic [SRC_N-1:0] act);
    logic [2:0] res;
    res = 3'b000;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (act[i]) res = {1'b1, 2'(i)};
    end
    return res;
  endfunction
endpackage

// File: rtl/mirq_sync.sv
module mirq_sync #(
  parameter int W     = 3,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg [DEPTH];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
      prev_q <= stg[DEPTH-1];
    end
  end

  assign sync_o = stg[DEPTH-1];
  assign rise_o = sync_o & ~prev_q;
endmodule

// File: rtl/mirq_pend.sv
module mirq_pend #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] raw_o
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else if (!edge_mode_i[i] || !en_i[i]) pend_q[i] <= 1'b0;
      else if (rise_i[i]) pend_q[i] <= 1'b1;
      else if (clr_i[i]) pend_q[i] <= 1'b0;
    end

    assign raw_o[i] = en_i[i] & (edge_mode_i[i] ? pend_q[i] : sync_i[i]);

    // R2: an accepted edge request is gone one cycle later unless a new edge came
    assert_edge_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !rise_i[i] && edge_mode_i[i]) |=> !pend_q[i]);
  end
endmodule

// File: rtl/mirq_typecap.sv
module mirq_typecap #(
  parameter int TYPE_W  = 8,
  parameter int ACK_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              casc_start_i,
  input  logic              slave_on_i,
  input  logic              arm_evt_i,
  input  logic              sel_evt_i,
  input  logic [TYPE_W-1:0] bus_i,
  output logic              ack_o,
  output logic [TYPE_W-1:0] type_o,
  output logic              valid_o
);
  localparam int CW = $clog2(ACK_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          cap_casc, cap_slave;

  assign cap_casc  = (cnt_q == CW'(1));
  assign cap_slave = slave_on_i & sel_evt_i & armed_q;
  assign ack_o     = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      type_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (casc_start_i && cnt_q == '0) cnt_q <= CW'(ACK_CYC);
      else if (cnt_q != '0)            cnt_q <= cnt_q - CW'(1);
      armed_q <= slave_on_i & (arm_evt_i | (armed_q & ~cap_slave));
      valid_o <= cap_casc | cap_slave;
      if (cap_casc || cap_slave) type_o <= bus_i;
    end
  end

  // R7: the end of an acknowledge pulse is always followed by a type strobe
  assert_ack_then_type_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> valid_o);
  // R7/R8: the type strobe lasts one cycle
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
endmodule

// File: rtl/mirq_front.sv
module mirq_front #(
  parameter int TYPE_W     = 8,
  parameter int ACK_CYC    = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        irq_pin_i,
  input  logic [2:0]        cfg_edge_i,
  input  logic [2:0]        cfg_mask_i,
  input  logic              cfg_cascade_i,
  input  logic              cfg_slave_i,
  input  logic [TYPE_W-1:0] type_bus_i,
  input  logic              cpu_ack_i,
  output logic              cpu_req_o,
  output logic [1:0]        cpu_src_o,
  output logic              inta_o,
  output logic              inta_oe_o,
  output logic [TYPE_W-1:0] type_o,
  output logic              type_valid_o
);
  import mirq_pkg::*;

  logic [SRC_N-1:0] sync_w, rise_w, en_w, clr_w, raw_w, act_w;
  logic [2:0]       pick_w;
  logic             slave_on, casc_start;

  assign slave_on = cfg_slave_i & ~cfg_cascade_i;
  assign en_w     = {~cfg_cascade_i, ~slave_on, 1'b1};

  mirq_sync #(.W(SRC_N), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_pin_i), .sync_o(sync_w), .rise_o(rise_w));

  for (genvar i = 0; i < SRC_N; i++) begin : g_clr
    assign clr_w[i] = cpu_ack_i & cpu_req_o & (cpu_src_o == 2'(i));
  end

  mirq_pend #(.N(SRC_N)) u_pend (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_w), .rise_i(rise_w),
    .edge_mode_i(cfg_edge_i), .en_i(en_w), .clr_i(clr_w), .raw_o(raw_w));

  assign act_w     = raw_w & ~cfg_mask_i;
  assign pick_w    = pick_first(act_w);
  assign cpu_req_o = pick_w[2];
  assign cpu_src_o = pick_w[1:0];

  assign casc_start = cfg_cascade_i & clr_w[0];
  assign inta_oe_o  = cfg_cascade_i;

  mirq_typecap #(.TYPE_W(TYPE_W), .ACK_CYC(ACK_CYC)) u_cap (
    .clk(clk), .rst_n(rst_n), .casc_start_i(casc_start), .slave_on_i(slave_on),
    .arm_evt_i(rise_w[0]), .sel_evt_i(rise_w[1]), .bus_i(type_bus_i),
    .ack_o(inta_o), .type_o(type_o), .valid_o(type_valid_o));

  // R3: a masked source is never presented
  assert_mask_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_o |-> !cfg_mask_i[cpu_src_o]);
  // R6: line 2 is not an interrupt while it serves as acknowledge
  assert_casc_no_src2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_o && cfg_cascade_i) |-> (cpu_src_o != 2'd2));
  // R8: line 1 is not an interrupt while it serves as select
  assert_slave_no_src1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_o && cfg_slave_i && !cfg_cascade_i) |-> (cpu_src_o != 2'd1));
  // R6: the acknowledge pulse only ever starts from an accepted source 0
  assert_inta_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inta_o) |-> $past(cpu_ack_i && cpu_req_o && cpu_src_o == 2'd0));
endmodule

// File: tb/sim_mirq_front.sv
module sim_mirq_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] irq_pin_i = '0, cfg_edge_i = '0, cfg_mask_i = '0;
  logic       cfg_cascade_i = 1'b0, cfg_slave_i = 1'b0, cpu_ack_i = 1'b0;
  logic [7:0] type_bus_i = '0;
  logic       cpu_req_o, inta_o, inta_oe_o, type_valid_o;
  logic [1:0] cpu_src_o;
  logic [7:0] type_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mirq_front u0 (.*);

  // vector: {pins[2:0], mask[2:0], exp_req, exp_src[1:0]}; level mode
  localparam logic [8:0] VEC [8] = '{
    {3'b111, 3'b000, 1'b1, 2'd0},
    {3'b110, 3'b000, 1'b1, 2'd1},
    {3'b100, 3'b000, 1'b1, 2'd2},
    {3'b111, 3'b001, 1'b1, 2'd1},
    {3'b111, 3'b011, 1'b1, 2'd2},
    {3'b111, 3'b111, 1'b0, 2'd0},
    {3'b101, 3'b100, 1'b1, 2'd0},
    {3'b000, 3'b000, 1'b0, 2'd0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    chk("R10 req", cpu_req_o, 0);
    chk("R10 inta", inta_o, 0);
    chk("R10 valid", type_valid_o, 0);
    chk("R10 type", type_o, 0);
    rst_n = 1'b1;
    tick(1);

    // R5/R3: priority and mask table walk
    foreach (VEC[k]) begin
      irq_pin_i  = VEC[k][8:6];
      cfg_mask_i = VEC[k][5:3];
      tick(2);
      chk($sformatf("R5 vec%0d req", k), cpu_req_o, VEC[k][2]);
      if (VEC[k][2]) chk($sformatf("R5 vec%0d src", k), cpu_src_o, VEC[k][1:0]);
    end
    cfg_mask_i = '0;
    tick(3);

    // R1: level latency
    irq_pin_i = 3'b100;
    tick(1);
    chk("R1 early", cpu_req_o, 0);
    tick(1);
    chk("R1 req", cpu_req_o, 1);
    chk("R1 src", cpu_src_o, 2);
    // R4: drop before ack
    irq_pin_i = 3'b000;
    tick(2);
    chk("R4 drop", cpu_req_o, 0);

    // R2: edge mode
    cfg_edge_i = 3'b001;
    irq_pin_i = 3'b001;
    tick(2);
    chk("R2 not yet", cpu_req_o, 0);
    tick(1);
    chk("R2 pend", cpu_req_o, 1);
    chk("R2 src", cpu_src_o, 0);
    irq_pin_i = 3'b000;
    tick(4);
    chk("R2 sticky", cpu_req_o, 1);
    cpu_ack_i = 1'b1;
    tick(1);
    cpu_ack_i = 1'b0;
    chk("R2 cleared", cpu_req_o, 0);

    // R3: event kept while masked
    cfg_mask_i = 3'b001;
    irq_pin_i = 3'b001;
    tick(2);
    irq_pin_i = 3'b000;
    tick(3);
    chk("R3 masked", cpu_req_o, 0);
    cfg_mask_i = 3'b000;
    #1;
    chk("R3 unmasked", cpu_req_o, 1);
    cpu_ack_i = 1'b1;
    tick(1);
    cpu_ack_i = 1'b0;
    chk("R3 acked", cpu_req_o, 0);

    // R6/R7: cascade
    cfg_cascade_i = 1'b1;
    irq_pin_i = 3'b100;
    tick(3);
    chk("R6 oe", inta_oe_o, 1);
    chk("R6 line2 ignored", cpu_req_o, 0);
    irq_pin_i = 3'b101;
    tick(3);
    chk("R6 src0 req", cpu_req_o, 1);
    chk("R6 inta idle", inta_o, 0);
    type_bus_i = 8'h11;
    cpu_ack_i = 1'b1;
    tick(1);
    cpu_ack_i = 1'b0;
    type_bus_i = 8'hA5;
    chk("R6 inta c1", inta_o, 1);
    tick(1);
    chk("R6 inta c2", inta_o, 1);
    chk("R7 no valid yet", type_valid_o, 0);
    tick(1);
    chk("R6 inta end", inta_o, 0);
    chk("R7 valid", type_valid_o, 1);
    chk("R7 type", type_o, 8'hA5);
    type_bus_i = 8'h00;
    tick(1);
    chk("R7 one cycle", type_valid_o, 0);
    irq_pin_i = 3'b000;
    cfg_cascade_i = 1'b0;
    tick(4);

    // R9/R8: slave mode
    cfg_slave_i = 1'b1;
    type_bus_i = 8'h77;
    irq_pin_i = 3'b010;
    begin
      int seen = 0, reqs = 0;
      for (int j = 0; j < 6; j++) begin
        tick(1);
        if (type_valid_o) seen++;
        if (cpu_req_o) reqs++;
      end
      chk("R9 unarmed select", seen, 0);
      chk("R8 line1 no req", reqs, 0);
    end
    irq_pin_i = 3'b000;
    tick(3);
    irq_pin_i = 3'b001;
    tick(3);
    chk("R8 src0 req", cpu_req_o, 1);
    type_bus_i = 8'h3C;
    irq_pin_i = 3'b011;
    tick(2);
    chk("R8 not yet", type_valid_o, 0);
    tick(1);
    chk("R8 valid", type_valid_o, 1);
    chk("R8 type", type_o, 8'h3C);
    tick(1);
    chk("R8 one cycle", type_valid_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule